// File: doc/BRIEF.md
# Bridged Interrupt Flag Controller

This block sits inside a bridge between a host bus and a downstream peripheral. Interrupt requests from the peripheral arrive as one-cycle pulses on two 16-bit request vectors. Each pulse sets the matching bit in one of two flag registers that the host can read. A registered, level-type interrupt line goes to the host. It is gated by a single global enable bit and by an internal arm state.

The host services an interrupt in four steps. It reads both flag registers, services the device, and writes the values it read back to the same registers; bits written as one are cleared. Writing to either flag register also disarms the line. The service routine ends by writing the key value 0x0FFF to the re-arm register. If any flag is still pending at that point, or arrives later, the line asserts again, so no event is lost.

The register window is 2^ADDR_W bytes wide. Inside it, a 0x30-byte block of registers repeats, so the register an address selects depends only on the address modulo 0x30.

Top module: `irq_flag_bridge`

## Requirements
- R1: After reset, the low flag register (offset 0x02) reads 0x0000, the high flag register (offset 0x18) reads 0x8008, the enable register (offset 0x1C) reads 0, the re-arm register (offset 0x1A) reads 0, the line is disarmed and irq_o is 0.
- R2: A one on bit i of req_lo_i (or req_hi_i) in a cycle sets bit i of the low (or high) flag register. The bit stays set until the host clears it.
- R3: A host write to offset 0x02 or 0x18 clears every flag bit of that register whose write-data bit is 1. Bits written as 0 keep their value.
- R4: When a request and a clearing write hit the same flag bit in the same cycle, the bit ends up set.
- R5: Bit 0 of the enable register at offset 0x1C is written from host_wdata_i[0] and reads back in bit 0 (other bits read 0). While it is 0, irq_o is 0 whatever flags are pending.
- R6: irq_o is registered. It goes to 1 one clock edge after the enable is 1, the line is armed and at least one flag bit is set. In the cycle the first flag sets, irq_o is still 0.
- R7: Any host write to offset 0x02 or 0x18 disarms the line. irq_o is 0 from the second edge after that write until the next re-arm, even when flags remain set.
- R8: A write of exactly 0x0FFF to offset 0x1A arms the line. A write of any other value there leaves the arm state unchanged.
- R9: Registers are selected by the address modulo 0x30, so address 0x48 reaches the high flag register and 0x4C reaches the enable register.
- R10: Offsets outside {0x02, 0x18, 0x1A, 0x1C} read 0, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_addr_i | input | ADDR_W | Byte address within the register window |
| host_wr_i | input | 1 | Host write strobe, one cycle per write |
| host_wdata_i | input | DATA_W | Host write data |
| host_rdata_o | output | DATA_W | Read data for host_addr_i (combinational) |
| req_lo_i | input | DATA_W | Downstream request pulses for the low flag register |
| req_hi_i | input | DATA_W | Downstream request pulses for the high flag register |
| irq_o | output | 1 | Registered level interrupt to the host |

## Verification
The bench builds the block with its default parameters: a 10-bit address, 16-bit data and a 0x30-byte repeat span. With these values the mirrored copies above 0x30 are in reach, and the bench reads and writes registers through them. The 16-bit data path lets the bench write the reset pattern 0x8008 back and race a request against a clear on the same bit. It also shows that a near-miss key such as 0x0FFE leaves the line disarmed.

// File: rtl/ifb_pkg.sv
package ifb_pkg;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_FLAG_LO,
        SEL_FLAG_HI,
        SEL_REARM,
        SEL_ENABLE
    } ifb_sel_e;

    typedef struct packed {
        logic en;
        logic armed;
        logic irq;
    } ifb_line_t;

endpackage

// File: rtl/ifb_decode.sv
module ifb_decode
    import ifb_pkg::*;
#(
    parameter int ADDR_W      = 10,
    parameter int WIN_SPAN    = 48,
    parameter int OFF_FLAG_LO = 2,
    parameter int OFF_FLAG_HI = 24,
    parameter int OFF_REARM   = 26,
    parameter int OFF_ENABLE  = 28
) (
    input  logic [ADDR_W-1:0] addr_i,
    output ifb_sel_e          sel_o
);

    localparam int SPAN_W = $clog2(WIN_SPAN);

    logic [SPAN_W-1:0] offset;

    always_comb begin
        offset = SPAN_W'(int'(addr_i) % WIN_SPAN);
        if (offset == SPAN_W'(OFF_FLAG_LO)) begin
            sel_o = SEL_FLAG_LO;
        end else if (offset == SPAN_W'(OFF_FLAG_HI)) begin
            sel_o = SEL_FLAG_HI;
        end else if (offset == SPAN_W'(OFF_REARM)) begin
            sel_o = SEL_REARM;
        end else if (offset == SPAN_W'(OFF_ENABLE)) begin
            sel_o = SEL_ENABLE;
        end else begin
            sel_o = SEL_NONE;
        end
    end

endmodule

// File: rtl/ifb_flag_bank.sv
module ifb_flag_bank #(
    parameter int               DATA_W  = 16,
    parameter logic [DATA_W-1:0] RST_VAL = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] req_i,
    input  logic              clr_wr_i,
    input  logic [DATA_W-1:0] clr_mask_i,
    output logic [DATA_W-1:0] flags_o
);

    logic [DATA_W-1:0] flags_d, flags_q;
    logic [DATA_W-1:0] clr_eff;

    always_comb begin
        clr_eff = clr_wr_i ? clr_mask_i : '0;
        // clear first, then set: a same-cycle request survives the clear
        flags_d = (flags_q & ~clr_eff) | req_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flags_q <= RST_VAL;
        end else begin
            flags_q <= flags_d;
        end
    end

    assign flags_o = flags_q;

endmodule

// File: rtl/ifb_line_ctrl.sv
module ifb_line_ctrl
    import ifb_pkg::*;
#(
    parameter int               DATA_W    = 16,
    parameter logic [DATA_W-1:0] REARM_KEY = DATA_W'(16'h0FFF)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_wr_i,
    input  logic              en_bit_i,
    input  logic              ack_wr_i,
    input  logic              rearm_wr_i,
    input  logic [DATA_W-1:0] rearm_data_i,
    input  logic              pending_i,
    output logic              en_o,
    output logic              armed_o,
    output logic              irq_o
);

    ifb_line_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (en_wr_i) begin
            st_d.en = en_bit_i;
        end
        if (ack_wr_i) begin
            st_d.armed = 1'b0;
        end else if (rearm_wr_i && (rearm_data_i == REARM_KEY)) begin
            st_d.armed = 1'b1;
        end
        st_d.irq = st_q.en & st_q.armed & pending_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign en_o    = st_q.en;
    assign armed_o = st_q.armed;
    assign irq_o   = st_q.irq;

endmodule

// File: rtl/irq_flag_bridge.sv
module irq_flag_bridge
    import ifb_pkg::*;
#(
    parameter int               ADDR_W      = 10,
    parameter int               DATA_W      = 16,
    parameter int               WIN_SPAN    = 48,
    parameter int               OFF_FLAG_LO = 2,
    parameter int               OFF_FLAG_HI = 24,
    parameter int               OFF_REARM   = 26,
    parameter int               OFF_ENABLE  = 28,
    parameter logic [DATA_W-1:0] REARM_KEY   = DATA_W'(16'h0FFF),
    parameter logic [DATA_W-1:0] LO_RST      = '0,
    parameter logic [DATA_W-1:0] HI_RST      = DATA_W'(16'h8008)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] host_addr_i,
    input  logic              host_wr_i,
    input  logic [DATA_W-1:0] host_wdata_i,
    output logic [DATA_W-1:0] host_rdata_o,
    input  logic [DATA_W-1:0] req_lo_i,
    input  logic [DATA_W-1:0] req_hi_i,
    output logic              irq_o
);

    localparam int NBANK = 2;

    ifb_sel_e          sel;
    logic [DATA_W-1:0] bank_req [NBANK];
    logic [DATA_W-1:0] bank_flg [NBANK];
    logic              bank_wr  [NBANK];
    logic [DATA_W-1:0] flag_lo_q, flag_hi_q;
    logic              en_q, armed_q;
    logic              ack_wr, pending;

    ifb_decode #(
        .ADDR_W     (ADDR_W),
        .WIN_SPAN   (WIN_SPAN),
        .OFF_FLAG_LO(OFF_FLAG_LO),
        .OFF_FLAG_HI(OFF_FLAG_HI),
        .OFF_REARM  (OFF_REARM),
        .OFF_ENABLE (OFF_ENABLE)
    ) u_decode (
        .addr_i(host_addr_i),
        .sel_o (sel)
    );

    assign bank_req[0] = req_lo_i;
    assign bank_req[1] = req_hi_i;
    assign bank_wr[0]  = host_wr_i && (sel == SEL_FLAG_LO);
    assign bank_wr[1]  = host_wr_i && (sel == SEL_FLAG_HI);

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        ifb_flag_bank #(
            .DATA_W (DATA_W),
            .RST_VAL((b == 0) ? LO_RST : HI_RST)
        ) u_bank (
            .clk       (clk),
            .rst_n     (rst_n),
            .req_i     (bank_req[b]),
            .clr_wr_i  (bank_wr[b]),
            .clr_mask_i(host_wdata_i),
            .flags_o   (bank_flg[b])
        );
    end

    assign flag_lo_q = bank_flg[0];
    assign flag_hi_q = bank_flg[1];
    assign ack_wr    = bank_wr[0] || bank_wr[1];
    assign pending   = (|flag_lo_q) || (|flag_hi_q);

    ifb_line_ctrl #(
        .DATA_W   (DATA_W),
        .REARM_KEY(REARM_KEY)
    ) u_line (
        .clk         (clk),
        .rst_n       (rst_n),
        .en_wr_i     (host_wr_i && (sel == SEL_ENABLE)),
        .en_bit_i    (host_wdata_i[0]),
        .ack_wr_i    (ack_wr),
        .rearm_wr_i  (host_wr_i && (sel == SEL_REARM)),
        .rearm_data_i(host_wdata_i),
        .pending_i   (pending),
        .en_o        (en_q),
        .armed_o     (armed_q),
        .irq_o       (irq_o)
    );

    always_comb begin
        host_rdata_o = '0;
        case (sel)
            SEL_FLAG_LO: host_rdata_o = flag_lo_q;
            SEL_FLAG_HI: host_rdata_o = flag_hi_q;
            SEL_ENABLE:  host_rdata_o = DATA_W'(en_q);
            default:     host_rdata_o = '0;
        endcase
    end

endmodule

// File: rtl/ifb_checker.sv
module ifb_checker #(
    parameter int               ADDR_W      = 10,
    parameter int               DATA_W      = 16,
    parameter int               WIN_SPAN    = 48,
    parameter int               OFF_FLAG_LO = 2,
    parameter int               OFF_FLAG_HI = 24,
    parameter int               OFF_REARM   = 26,
    parameter logic [DATA_W-1:0] REARM_KEY   = DATA_W'(16'h0FFF),
    parameter logic [DATA_W-1:0] HI_RST      = DATA_W'(16'h8008)
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] host_addr_i,
    input logic              host_wr_i,
    input logic [DATA_W-1:0] host_wdata_i,
    input logic [DATA_W-1:0] req_lo_i,
    input logic [DATA_W-1:0] req_hi_i,
    input logic              irq_o,
    input logic [DATA_W-1:0] flag_lo_q,
    input logic [DATA_W-1:0] flag_hi_q,
    input logic              en_q,
    input logic              armed_q
);

    int  off;
    logic wr_lo, wr_hi, wr_key;

    always_comb begin
        off    = int'(host_addr_i) % WIN_SPAN;
        wr_lo  = host_wr_i && (off == OFF_FLAG_LO);
        wr_hi  = host_wr_i && (off == OFF_FLAG_HI);
        wr_key = host_wr_i && (off == OFF_REARM);
    end

    AST_RESET_STATE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (flag_hi_q == HI_RST && flag_lo_q == '0 && !irq_o && !armed_q)); // R1

    AST_REQ_LATCHES_LO: assert property (@(posedge clk) disable iff (!rst_n)
        (|req_lo_i) |=> ((flag_lo_q & $past(req_lo_i)) == $past(req_lo_i))); // R2

    AST_SET_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_hi && (|req_hi_i)) |=> ((flag_hi_q & $past(req_hi_i)) == $past(req_hi_i))); // R4

    AST_CLEAR_LO: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_lo && req_lo_i == '0) |=> ((flag_lo_q & $past(host_wdata_i)) == '0)); // R3

    AST_MASK_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !en_q |=> !irq_o); // R5

    AST_LINE_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        (en_q && armed_q && ((|flag_lo_q) || (|flag_hi_q))) |=> irq_o); // R6

    AST_ACK_DISARMS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_lo || wr_hi) |=> !armed_q); // R7

    AST_DISARMED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !armed_q |=> !irq_o); // R7

    AST_BAD_KEY: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_key && host_wdata_i != REARM_KEY && !armed_q) |=> !armed_q); // R8

    AST_GOOD_KEY: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_key && host_wdata_i == REARM_KEY) |=> armed_q); // R8

endmodule

bind irq_flag_bridge ifb_checker #(
    .ADDR_W     (ADDR_W),
    .DATA_W     (DATA_W),
    .WIN_SPAN   (WIN_SPAN),
    .OFF_FLAG_LO(OFF_FLAG_LO),
    .OFF_FLAG_HI(OFF_FLAG_HI),
    .OFF_REARM  (OFF_REARM),
    .REARM_KEY  (REARM_KEY),
    .HI_RST     (HI_RST)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .host_addr_i (host_addr_i),
    .host_wr_i   (host_wr_i),
    .host_wdata_i(host_wdata_i),
    .req_lo_i    (req_lo_i),
    .req_hi_i    (req_hi_i),
    .irq_o       (irq_o),
    .flag_lo_q   (flag_lo_q),
    .flag_hi_q   (flag_hi_q),
    .en_q        (en_q),
    .armed_q     (armed_q)
);

// File: tb/irq_flag_bridge_tb_top.sv
module irq_flag_bridge_tb_top;

    localparam int ADDR_W = 10;
    localparam int DATA_W = 16;

    typedef struct {
        int          kind;   // 0: read data, 1: irq line
        logic [15:0] exp;
        string       tag;
    } item_t;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [ADDR_W-1:0] host_addr_i = '0;
    logic              host_wr_i = 1'b0;
    logic [DATA_W-1:0] host_wdata_i = '0;
    logic [DATA_W-1:0] host_rdata_o;
    logic [DATA_W-1:0] req_lo_i = '0;
    logic [DATA_W-1:0] req_hi_i = '0;
    logic              irq_o;

    int    checks = 0;
    int    errors = 0;
    logic  probe_valid = 1'b0;
    item_t exp_q[$];

    always #5 clk = ~clk;

    irq_flag_bridge dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .host_addr_i (host_addr_i),
        .host_wr_i   (host_wr_i),
        .host_wdata_i(host_wdata_i),
        .host_rdata_o(host_rdata_o),
        .req_lo_i    (req_lo_i),
        .req_hi_i    (req_hi_i),
        .irq_o       (irq_o)
    );

    // monitor: pop the expected item and compare with the observed port
    always @(negedge clk) begin
        if (probe_valid) begin
            item_t       it;
            logic [15:0] act;
            checks++;
            if (exp_q.size() == 0) begin
                errors++;
                $display("FAIL scoreboard empty: act irq=%0b rdata=%h exp none", irq_o, host_rdata_o);
            end else begin
                it  = exp_q.pop_front();
                act = (it.kind == 1) ? 16'(irq_o) : host_rdata_o;
                if (act !== it.exp) begin
                    errors++;
                    $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
                end
            end
        end
    end

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(posedge clk);
        #1;
    endtask

    task automatic wr(input logic [ADDR_W-1:0] a, input logic [15:0] d);
        @(posedge clk); #1;
        host_addr_i = a; host_wdata_i = d; host_wr_i = 1'b1;
        @(posedge clk); #1;
        host_wr_i = 1'b0;
    endtask

    task automatic pulse(input logic [15:0] lo, input logic [15:0] hi);
        @(posedge clk); #1;
        req_lo_i = lo; req_hi_i = hi;
        @(posedge clk); #1;
        req_lo_i = '0; req_hi_i = '0;
    endtask

    task automatic wr_race_hi(input logic [15:0] d, input logic [15:0] hi);
        @(posedge clk); #1;
        host_addr_i = 10'h018; host_wdata_i = d; host_wr_i = 1'b1; req_hi_i = hi;
        @(posedge clk); #1;
        host_wr_i = 1'b0; req_hi_i = '0;
    endtask

    task automatic probe(input int kind, input logic [15:0] e, input string tag);
        item_t it;
        it.kind = kind; it.exp = e; it.tag = tag;
        exp_q.push_back(it);
        probe_valid = 1'b1;
        @(negedge clk); #1;
        probe_valid = 1'b0;
    endtask

    task automatic rd(input logic [ADDR_W-1:0] a, input logic [15:0] e, input string tag);
        @(posedge clk); #1;
        host_addr_i = a;
        probe(0, e, tag);
    endtask

    task automatic chk_irq(input logic e, input string tag);
        @(posedge clk); #1;
        probe(1, 16'(e), tag);
    endtask

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(1);

        // reset state
        rd(10'h002, 16'h0000, "R1 low flags reset");
        rd(10'h018, 16'h8008, "R1 high flags reset");
        rd(10'h01C, 16'h0000, "R1 enable reset");
        rd(10'h01A, 16'h0000, "R1 rearm reads zero");
        chk_irq(1'b0, "R1 irq low after reset");

        // unmapped offset
        rd(10'h005, 16'h0000, "R10 unmapped reads zero");
        wr(10'h01D, 16'hFFFF);
        rd(10'h01C, 16'h0000, "R10 unmapped write leaves enable");
        rd(10'h018, 16'h8008, "R10 unmapped write leaves flags");

        // mirror
        rd(10'h048, 16'h8008, "R9 mirrored high flags");

        // write-one-to-clear
        wr(10'h018, 16'h0008);
        rd(10'h018, 16'h8000, "R3 partial clear");
        wr(10'h018, 16'h8000);
        rd(10'h018, 16'h0000, "R3 full clear");

        // request latching
        pulse(16'h0011, 16'h0200);
        idle(2);
        rd(10'h002, 16'h0011, "R2 low flags latched");
        rd(10'h018, 16'h0200, "R2 high flags latched");

        // masked pending interrupt: armed, pending, disabled
        wr(10'h01A, 16'h0FFF);
        idle(3);
        chk_irq(1'b0, "R5 masked pending stays low");

        // enable through the mirror
        wr(10'h04C, 16'h0001);
        rd(10'h01C, 16'h0001, "R9 R5 enable via mirror");
        idle(1);
        chk_irq(1'b1, "R5 enabled pending asserts");

        // acknowledge without new event
        wr(10'h002, 16'h0011);
        idle(1);
        chk_irq(1'b0, "R7 ack disarms line");
        rd(10'h002, 16'h0000, "R3 ack clears low flags");

        // wrong key ignored, right key re-arms
        wr(10'h01A, 16'h0FFE);
        idle(2);
        chk_irq(1'b0, "R8 wrong key ignored");
        wr(10'h01A, 16'h0FFF);
        idle(2);
        chk_irq(1'b1, "R8 rearm with pending flag");

        // acknowledge racing a new event on the same bit
        wr_race_hi(16'h0200, 16'h0200);
        rd(10'h018, 16'h0200, "R4 request beats clear");
        idle(2);
        chk_irq(1'b0, "R7 raced ack still disarmed");
        wr(10'h01A, 16'h0FFF);
        idle(2);
        chk_irq(1'b1, "R4 raced event re-asserts");
        wr(10'h018, 16'h0200);
        rd(10'h018, 16'h0000, "R3 raced flag cleared");

        // registered timing
        wr(10'h01A, 16'h0FFF);
        idle(2);
        chk_irq(1'b0, "R6 armed, nothing pending");
        pulse(16'h8000, 16'h0000);
        probe(1, 16'h0000, "R6 low in flag-set cycle");
        chk_irq(1'b1, "R6 high one edge later");

        // disable while pending
        wr(10'h01C, 16'h0000);
        idle(1);
        chk_irq(1'b0, "R5 disable masks pending");
        rd(10'h002, 16'h8000, "R5 flag kept while masked");

        idle(2);
        if (exp_q.size() != 0) begin
            errors++;
            $display("FAIL scoreboard leftover: actual %0d expected 0", exp_q.size());
        end
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(200000 * 10);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule